// File: doc/BRIEF.md
# Register-Bus JTAG Bit-Bang Port

This block lets software drive a JTAG chain one bit at a time through a 32-bit register bus, for tasks such as reprogramming a configuration memory. Each write to the shift-command address sets TMS and TDI from the write data and then produces a single TCK pulse with fixed timing. The pulse is counted in system clocks. On every rising TCK edge the block samples TDO into a capture register that shifts toward bit 0. Host software reads this register back from the same address. Bit 31 of the read value always shows the present TDO level.

A second address holds the output-enable bit. While it is clear, the TCK, TMS and TDI pins are held low and the pin-enable output is low, so the chain may be driven by another master. TDO passes through a two-flop synchronizer before the block uses it. A busy output is high while a pulse is in progress, and a new shift command is refused until that pulse ends. Bus reads are registered and return data one clock after the read strobe.

Top module: `jtag_bitbang_port`

## Requirements
- R1: A write to the shift-command address (default 0x04) while idle takes TDI from write-data bit 0 and TMS from write-data bit 1, drives them on the pins one clock after the write edge, and produces exactly one TCK pulse.
- R2: With the write at edge E0, TCK on the pin is high after edges E0+SETUP_CYC+1 through E0+SETUP_CYC+HIGH_CYC, so TMS and TDI lead the rising edge by SETUP_CYC clocks. Busy is high after edges E0 through E0+SETUP_CYC+HIGH_CYC+LOW_CYC-1.
- R3: At each internal TCK rise, the 31-bit capture register shifts right by one. The synchronized TDO enters bit 30 and the old bit 0 is lost. The register does not change at any other time.
- R4: A read of the shift-command address returns {live TDO, capture[30:0]} on the read-data bus one clock after the read strobe.
- R5: Read bit 31 follows the TDO pin through two synchronizer flops, with no TCK needed, and a change of TDO alone leaves bits 30:0 as they were.
- R6: Control-address (default 0x08) write-data bit 0 sets the pin enable. A read of that address returns the enable in bit 0, with all other bits zero.
- R7: While the pin enable is 0, the TCK, TMS, TDI and pin-enable outputs stay low, but a shift command still runs its pulse internally and still shifts the capture register.
- R8: A shift-command write while busy is high is ignored: no extra pulse, TMS and TDI unchanged, and exactly one capture shift for the pulse already running.
- R9: Writes to any other address have no effect, and reads of any other address return zero.
- R10: Synchronous reset clears the capture register and the enable, drives TCK, TMS, TDI and pin-enable low, and leaves busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one clock after bus_rd |
| busy | output | 1 | A TCK pulse is in progress |
| jtag_tck | output | 1 | Test clock to the chain |
| jtag_tms | output | 1 | Test mode select to the chain |
| jtag_tdi | output | 1 | Test data to the chain |
| jtag_oe | output | 1 | Enable for the TCK/TMS/TDI pin drivers |
| jtag_tdo | input | 1 | Test data from the chain, asynchronous |

## Verification
A table of eight shift commands runs through every combination of TMS and TDI against TDO at both levels. For each command the bench checks the TCK and busy waveform clock by clock, the TMS and TDI pin levels, and the capture value read back against a shift model. Mixed TDO patterns separate a right shift entering at bit 30 from a left shift or a wrong entry bit, and they expose a lost or doubled shift. Directed cases cover the rest. A command issued mid-pulse must leave the waveform and pins unchanged. A disabled run keeps the pins dark but still captures. A TDO toggle with no TCK moves only bit 31. A stray address must have no effect, and a reset part-way through a run must clear everything.

// File: rtl/jbb_pkg.sv
package jbb_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SETUP = 2'd1,
    SEQ_HIGH  = 2'd2,
    SEQ_LOW   = 2'd3
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/jbb_tdo_sync.sv
module jbb_tdo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/jbb_tck_seq.sv
module jbb_tck_seq
  import jbb_pkg::*;
#(
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 3,
  parameter int LOW_CYC   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic req_tms,
  input  logic req_tdi,
  output logic busy,
  output logic tck,
  output logic tms,
  output logic tdi,
  output logic tck_rise
);
  localparam int CNT_MAX = max3(SETUP_CYC, HIGH_CYC, LOW_CYC);
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HIGH_LD  = CNT_W'(HIGH_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_LD   = CNT_W'(LOW_CYC - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_done;

  assign cnt_done = (cnt == '0);
  assign busy     = (state != SEQ_IDLE);
  assign tck_rise = (state == SEQ_SETUP) && cnt_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
      tck   <= 1'b0;
      tms   <= 1'b0;
      tdi   <= 1'b0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          if (start) begin
            tms   <= req_tms;
            tdi   <= req_tdi;
            cnt   <= SETUP_LD;
            state <= SEQ_SETUP;
          end
        end
        SEQ_SETUP: begin
          if (cnt_done) begin
            tck   <= 1'b1;
            cnt   <= HIGH_LD;
            state <= SEQ_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_HIGH: begin
          if (cnt_done) begin
            tck   <= 1'b0;
            cnt   <= LOW_LD;
            state <= SEQ_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_LOW: begin
          if (cnt_done) state <= SEQ_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R1: TCK only rises out of the setup phase
  p_rise_from_setup_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(tck) |-> $past(state) == SEQ_SETUP);
  // R1: TCK is low whenever the sequencer is idle
  p_idle_tck_low_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tck);
  // R2: TMS/TDI already settled when TCK rises
  p_setup_stable_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(tck) |-> $stable(tms) && $stable(tdi));
  // R8: request values are not taken while busy
  p_hold_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(tms) && $stable(tdi));
endmodule

// File: rtl/jbb_capture.sv
module jbb_capture #(
  parameter int CAP_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift,
  input  logic             din,
  output logic [CAP_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (shift) q <= {din, q[CAP_W-1:1]};
  end

  // R3: right shift with new bit at the top of the capture field
  p_shift_right_r3: assert property (@(posedge clk) disable iff (rst)
    shift |=> (q[CAP_W-2:0] == $past(q[CAP_W-1:1])) && (q[CAP_W-1] == $past(din)));
  // R3: no change without a TCK rise
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !shift |=> $stable(q));
endmodule

// File: rtl/jtag_bitbang_port.sv
module jtag_bitbang_port #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SYNC_STG  = 2,
  parameter int SETUP_CYC = 2,
  parameter int HIGH_CYC  = 3,
  parameter int LOW_CYC   = 2,
  parameter logic [ADDR_W-1:0] ADDR_SHIFT = 8'h04,
  parameter logic [ADDR_W-1:0] ADDR_CTRL  = 8'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              jtag_tck,
  output logic              jtag_tms,
  output logic              jtag_tdi,
  output logic              jtag_oe,
  input  logic              jtag_tdo
);
  localparam int CAP_W = DATA_W - 1;

  logic             hit_shift, hit_ctrl;
  logic             tdo_s;
  logic             seq_tck, seq_tms, seq_tdi, seq_rise;
  logic             en_q;
  logic [CAP_W-1:0] cap_q;
  logic             unused_wdata;

  assign hit_shift    = (bus_addr == ADDR_SHIFT);
  assign hit_ctrl     = (bus_addr == ADDR_CTRL);
  assign unused_wdata = ^bus_wdata[DATA_W-1:2];

  jbb_tdo_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (jtag_tdo),
    .sync_out (tdo_s)
  );

  jbb_tck_seq #(
    .SETUP_CYC (SETUP_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .LOW_CYC   (LOW_CYC)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (bus_wr && hit_shift),
    .req_tms  (bus_wdata[1]),
    .req_tdi  (bus_wdata[0]),
    .busy     (busy),
    .tck      (seq_tck),
    .tms      (seq_tms),
    .tdi      (seq_tdi),
    .tck_rise (seq_rise)
  );

  jbb_capture #(.CAP_W(CAP_W)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .shift (seq_rise),
    .din   (tdo_s),
    .q     (cap_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                  en_q <= 1'b0;
    else if (bus_wr && hit_ctrl) en_q <= bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      jtag_tck <= 1'b0;
      jtag_tms <= 1'b0;
      jtag_tdi <= 1'b0;
      jtag_oe  <= 1'b0;
    end else begin
      jtag_tck <= en_q & seq_tck;
      jtag_tms <= en_q & seq_tms;
      jtag_tdi <= en_q & seq_tdi;
      jtag_oe  <= en_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (hit_shift)     bus_rdata <= {tdo_s, cap_q};
      else if (hit_ctrl) bus_rdata <= {{(DATA_W-1){1'b0}}, en_q};
      else               bus_rdata <= '0;
    end
  end

  // R7: pins dark one clock after the enable is clear
  p_pins_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !jtag_tck && !jtag_tms && !jtag_tdi && !jtag_oe);
  // R2: a pin TCK high never appears outside a busy window
  p_tck_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(jtag_tck) |-> busy);
  // R10: reset leaves the pins low
  p_reset_pins_r10: assert property (@(posedge clk)
    rst |=> !jtag_tck && !jtag_oe && !busy);
endmodule

// File: tb/tb_jtag_bitbang_port.sv
module tb_jtag_bitbang_port;
  localparam int CLK_PERIOD = 10;
  localparam int S = 2, H = 3, L = 2;
  localparam logic [7:0] A_SHIFT = 8'h04, A_CTRL = 8'h08, A_OTHER = 8'h0C;
  // vector: {tms, tdi, tdo}
  localparam logic [2:0] VEC [8] = '{3'b001, 3'b010, 3'b100, 3'b111,
                                     3'b000, 3'b011, 3'b101, 3'b110};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        busy, jtag_tck, jtag_tms, jtag_tdi, jtag_oe;
  logic        jtag_tdo = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [30:0] model = '0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_bitbang_port dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .jtag_tck(jtag_tck), .jtag_tms(jtag_tms), .jtag_tdi(jtag_tdi),
    .jtag_oe(jtag_oe), .jtag_tdo(jtag_tdo)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // one shift command; checks TCK/busy/pin waveform per clock (R1, R2, R7, R8)
  task automatic pulse(input logic tms, input logic tdi, input logic en, input logic poke);
    int bad = 0;
    @(negedge clk);
    bus_addr = A_SHIFT; bus_wdata = {30'd0, tms, tdi}; bus_wr = 1'b1;
    for (int k = 0; k <= S + H + L + 1; k++) begin
      @(negedge clk);
      bus_wr = 1'b0;
      if (poke && k == 2) begin
        bus_wdata = {30'd0, ~tms, ~tdi}; bus_wr = 1'b1;
      end
      if (jtag_tck !== (en && k >= S + 1 && k <= S + H)) bad++;
      if (busy !== (k <= S + H + L - 1)) bad++;
      if (k >= 1 && (jtag_tms !== (en & tms) || jtag_tdi !== (en & tdi))) bad++;
      if (jtag_oe !== en) bad++;
    end
    bus_wr = 1'b0;
    model = {jtag_tdo, model[30:1]};
    check(poke ? "R8 waveform with mid-pulse write" :
          (en ? "R1/R2 pulse waveform" : "R7 disabled waveform"), bad, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 pins after reset", {jtag_tck, jtag_tms, jtag_tdi, jtag_oe, busy}, 0);
    bus_read(A_SHIFT, rd);
    check("R10 capture after reset", rd, 0);
    bus_read(A_CTRL, rd);
    check("R10 enable after reset", rd, 0);

    bus_write(A_CTRL, 32'h1);
    bus_read(A_CTRL, rd);
    check("R6 enable readback", rd, 32'h1);

    // vector table: R1 R2 R3 R4
    foreach (VEC[i]) begin
      jtag_tdo = VEC[i][0];
      repeat (4) @(negedge clk);
      pulse(VEC[i][2], VEC[i][1], 1'b1, 1'b0);
      check("R1 tms/tdi pins", {jtag_tms, jtag_tdi}, {VEC[i][2], VEC[i][1]});
      bus_read(A_SHIFT, rd);
      check("R3/R4 capture read", rd, {jtag_tdo, model});
    end

    // R5 live TDO without TCK
    jtag_tdo = ~jtag_tdo;
    repeat (3) @(negedge clk);
    bus_read(A_SHIFT, rd);
    check("R5 live TDO bit31", rd, {jtag_tdo, model});

    // R8 write while busy ignored
    jtag_tdo = 1'b1;
    repeat (4) @(negedge clk);
    pulse(1'b1, 1'b1, 1'b1, 1'b1);
    check("R8 pins keep first request", {jtag_tms, jtag_tdi}, 2'b11);
    bus_read(A_SHIFT, rd);
    check("R8 single shift", rd, {1'b1, model});

    // R9 other address
    bus_write(A_OTHER, 32'h0000_0000);
    @(negedge clk);
    check("R9 no effect of stray write", {busy, jtag_oe, jtag_tms, jtag_tdi}, 4'b0111);
    bus_read(A_OTHER, rd);
    check("R9 stray read zero", rd, 0);

    // R7 disabled: pins dark, capture still shifts
    bus_write(A_CTRL, 32'hFFFF_FFFE);
    jtag_tdo = 1'b0;
    repeat (4) @(negedge clk);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    check("R7 pins low when disabled", {jtag_tck, jtag_tms, jtag_tdi, jtag_oe}, 0);
    bus_read(A_SHIFT, rd);
    check("R7 capture shifts when disabled", rd, {1'b0, model});
    bus_read(A_CTRL, rd);
    check("R6 enable cleared readback", rd, 0);

    // R10 reset mid-pulse
    bus_write(A_CTRL, 32'h1);
    jtag_tdo = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(A_SHIFT, 32'h3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 pins after mid-pulse reset", {jtag_tck, jtag_tms, jtag_tdi, jtag_oe, busy}, 0);
    bus_read(A_SHIFT, rd);
    check("R10 capture cleared", rd[30:0], 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule